// File: doc/BRIEF.md
# Three-Dimensional Bit-Reverse Reorder Buffer

This block sits at the tail of a fast 3-D cosine-transform pipeline, directly after the post-addition stage. That pipeline delivers the coefficients of each N×N×N cube as a serial stream, one word per clock. Within each cube, the row, column and frame indices of the stream are each bit-reversed. The buffer writes every incoming word into a dual-port RAM at its arrival position. It then reads the words back so that the output stream lists the coefficients in natural order. Its output is therefore the final transform result, and it can also act as the elastic stage in front of a quantiser.

The RAM holds two cube-sized regions that alternate. While one region fills with cube k+1, the other drains cube k. Back-to-back cubes therefore stream through with no stall and no gap. An input marker flags the first word of a cube. A marker seen part way through a cube abandons the partial cube and starts a new one.

Two small state machines control the block. The writer has states WR_EMPTY and WR_FILLING:
- WR_EMPTY moves to WR_FILLING when a word is accepted.
- WR_FILLING returns to WR_EMPTY when the last word of a cube is accepted, and then switches region.
- WR_FILLING stays in WR_FILLING at position 1 on a restart marker.

The reader has states RD_IDLE and RD_DRAIN:
- RD_IDLE moves to RD_DRAIN when its current region holds a complete cube.
- RD_DRAIN stays in RD_DRAIN after the final read when the other region is already complete, which is the seamless hand-over.
- Otherwise RD_DRAIN drops back to RD_IDLE after the final read.

Top module: `cube_bitrev_reorder`

## Requirements
- R1: After reset, out_valid is low, and it stays low until a complete cube of N³ words has been accepted.
- R2: A cube index k has three LOG_N-bit fields: bits [LOG_N-1:0] hold the row, the next LOG_N bits hold the column, and the top LOG_N bits hold the frame. The k-th output word of a cube is the input word accepted at position rev(row) + rev(column)·N + rev(frame)·N². Here rev reverses the bit order of a single field, and position 0 is the first word accepted.
- R3: When the reader is idle and no cube is waiting, the first output word of a cube is valid after the second rising edge that follows the edge that accepted the cube's last word.
- R4: The N³ output words of a cube appear on consecutive cycles. When cubes arrive back to back with no idle input cycles, their outputs also follow each other with no idle cycle, one cube every N³ cycles.
- R5: Cycles with in_valid low are ignored. Gaps in the input stream do not change the output order or content.
- R6: A word accepted with in_first high becomes position 0 of a new cube, and the words of an unfinished cube are discarded without producing output. An in_first on a word that is already at position 0 has no effect.
- R7: Each completed cube yields exactly N³ output words. out_valid is low whenever no completed cube remains unread.
- R8: The writer never completes a cube into a region that still holds an unread cube, because a region is freed before the next cube destined for it can finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_first | input | 1 | Marks the input word as position 0 of a cube |
| in_data | input | DATA_W | Coefficient in bit-reversed index order |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | DATA_W | Coefficient in natural index order |

## Verification
The bench tags every word with its cube and its arrival position. A design that reversed the whole address instead of each field, or that swapped the field order, therefore shows up on the first mismatched word. It measures the cycle of each cube's first output. A reader that waits an extra cycle at start-up, or that drops to idle between back-to-back cubes, shifts those cycles and is caught. Restart markers are placed after a short partial cube, after a cube one word short of complete, and on a word already at a cube boundary. A writer that keeps a stale count, or that emits an abandoned cube, produces extra or corrupted output. A final idle window confirms that out_valid stays low once every cube has drained.

// File: rtl/cube_reorder_pkg.sv
package cube_reorder_pkg;

    typedef enum logic {
        WR_EMPTY   = 1'b0,
        WR_FILLING = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_DRAIN = 1'b1
    } rd_state_e;

    localparam int NUM_FIELDS = 3;

endpackage

// File: rtl/field_reverse.sv
module field_reverse #(
    parameter int LOG_N = 2,
    localparam int IDX_W = cube_reorder_pkg::NUM_FIELDS * LOG_N
) (
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] rev
);
    // Each field is mirrored on its own; fields keep their place.
    for (genvar f = 0; f < cube_reorder_pkg::NUM_FIELDS; f++) begin : g_field
        for (genvar b = 0; b < LOG_N; b++) begin : g_bit
            assign rev[f*LOG_N + b] = idx[f*LOG_N + (LOG_N-1-b)];
        end
    end
endmodule

// File: rtl/cube_writer.sv
module cube_writer
    import cube_reorder_pkg::*;
#(
    parameter int LOG_N = 2,
    localparam int IDX_W = NUM_FIELDS * LOG_N,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_done,
    output logic              wr_bank,
    output logic [IDX_W-1:0]  wr_cnt
);
    wr_state_e       state_q;
    logic [IDX_W-1:0] cnt_q;
    logic            bank_q;
    logic [IDX_W-1:0] pos;
    logic            last;

    always_comb begin
        pos = (state_q == WR_EMPTY || in_first) ? '0 : cnt_q;
        last = (pos == '1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_EMPTY;
            cnt_q   <= '0;
            bank_q  <= 1'b0;
        end else if (in_valid) begin
            unique case (state_q)
                WR_EMPTY, WR_FILLING: begin
                    if (last) begin
                        state_q <= WR_EMPTY;
                        cnt_q   <= '0;
                        bank_q  <= ~bank_q;
                    end else begin
                        state_q <= WR_FILLING;
                        cnt_q   <= pos + 1'b1;
                    end
                end
                default: state_q <= WR_EMPTY;
            endcase
        end
    end

    always_comb begin
        wr_en   = in_valid;
        wr_addr = {bank_q, pos};
        wr_done = in_valid && last;
        wr_bank = bank_q;
        wr_cnt  = cnt_q;
    end
endmodule

// File: rtl/cube_reader.sv
module cube_reader
    import cube_reorder_pkg::*;
#(
    parameter int LOG_N = 2,
    localparam int IDX_W = NUM_FIELDS * LOG_N,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_in,
    input  logic              done_bank,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        pending,
    output logic              rd_idle
);
    rd_state_e        state_q;
    logic [IDX_W-1:0] cnt_q;
    logic             bank_q;
    logic [1:0]       pend_q;
    logic [1:0]       pend_d;
    logic [IDX_W-1:0] cnt_rev;
    logic             rd_last;

    field_reverse #(.LOG_N(LOG_N)) i_rev (
        .idx (cnt_q),
        .rev (cnt_rev)
    );

    always_comb begin
        rd_last = (state_q == RD_DRAIN) && (cnt_q == '1);
        pend_d  = pend_q;
        if (rd_last) pend_d[bank_q] = 1'b0;
        if (done_in) pend_d[done_bank] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            cnt_q   <= '0;
            bank_q  <= 1'b0;
            pend_q  <= 2'b00;
        end else begin
            pend_q <= pend_d;
            unique case (state_q)
                RD_IDLE: begin
                    cnt_q <= '0;
                    if (pend_q[bank_q]) state_q <= RD_DRAIN;
                end
                RD_DRAIN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (rd_last) begin
                        bank_q  <= ~bank_q;
                        state_q <= pend_q[~bank_q] ? RD_DRAIN : RD_IDLE;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_en   = (state_q == RD_DRAIN);
        rd_addr = {bank_q, cnt_rev};
        pending = pend_q;
        rd_idle = (state_q == RD_IDLE);
    end
endmodule

// File: rtl/cube_ram.sv
module cube_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/cube_bitrev_reorder.sv
module cube_bitrev_reorder
    import cube_reorder_pkg::*;
#(
    parameter int LOG_N = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int IDX_W = NUM_FIELDS * LOG_N;
    localparam int ADDR_W = IDX_W + 1;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_done;
    logic              wr_bank;
    logic [IDX_W-1:0]  wr_cnt;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [1:0]        pending;
    logic              rd_idle;
    logic              out_valid_q;

    cube_writer #(.LOG_N(LOG_N)) i_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_done  (wr_done),
        .wr_bank  (wr_bank),
        .wr_cnt   (wr_cnt)
    );

    cube_reader #(.LOG_N(LOG_N)) i_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_in   (wr_done),
        .done_bank (wr_bank),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .pending   (pending),
        .rd_idle   (rd_idle)
    );

    cube_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (out_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid_q <= 1'b0;
        else        out_valid_q <= rd_en;
    end

    assign out_valid = out_valid_q;
endmodule

// File: rtl/cube_reorder_checker.sv
module cube_reorder_checker #(
    parameter int LOG_N = 2,
    localparam int IDX_W = 3 * LOG_N
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_first,
    input logic             wr_done,
    input logic             wr_bank,
    input logic [IDX_W-1:0] wr_cnt,
    input logic [1:0]       pending,
    input logic             rd_idle,
    input logic             out_valid
);
    logic [15:0]      cubes_done;
    logic [15:0]      cubes_read;
    logic [IDX_W-1:0] out_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cubes_done <= '0;
            cubes_read <= '0;
            out_cnt    <= '0;
        end else begin
            if (wr_done) cubes_done <= cubes_done + 1'b1;
            if (out_valid) begin
                out_cnt <= out_cnt + 1'b1;
                if (out_cnt == '1) cubes_read <= cubes_read + 1'b1;
            end
        end
    end

    assert_idle_until_cube_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cubes_done == 16'd0) |-> !out_valid);

    assert_start_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && rd_idle && pending == 2'b00) |=> ##2 out_valid);

    assert_no_gap_in_cube_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cnt != '1) |=> out_valid);

    assert_restart_position_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first) |=> (wr_cnt == IDX_W'(1)));

    assert_no_orphan_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cubes_done != cubes_read));

    assert_bank_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> !pending[wr_bank]);
endmodule

bind cube_bitrev_reorder cube_reorder_checker #(.LOG_N(LOG_N)) i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .wr_done   (wr_done),
    .wr_bank   (wr_bank),
    .wr_cnt    (wr_cnt),
    .pending   (pending),
    .rd_idle   (rd_idle),
    .out_valid (out_valid)
);

// File: tb/test_cube_bitrev_reorder.sv
module test_cube_bitrev_reorder;
    localparam int LOG_N = 2;
    localparam int DATA_W = 16;
    localparam int CUBE = 1 << (3 * LOG_N);
    localparam int NVEC = 6;
    // stimulus table: gap pattern and whether in_first marks the first word
    localparam int GAP_TBL[NVEC]   = '{0, 0, 0, 1, 2, 0};
    localparam int FIRST_TBL[NVEC] = '{0, 0, 1, 0, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_first = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic [DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    bit mon_en = 0;
    int exp_ids[16];
    int lacc[16];
    int fv[16];
    int n_sent = 0;
    int out_total = 0;
    int out_k = 0;
    int out_cube = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cube_bitrev_reorder #(.LOG_N(LOG_N), .DATA_W(DATA_W)) i_cube_bitrev_reorder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_first  (in_first),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int fld_rev(input int k);
        int r = 0;
        for (int f = 0; f < 3; f++)
            for (int b = 0; b < LOG_N; b++)
                if (k[f*LOG_N + b]) r[f*LOG_N + (LOG_N-1-b)] = 1'b1;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: R2 ordering of every output word
    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            logic [DATA_W-1:0] exp;
            exp = {exp_ids[out_cube][7:0], 8'(fld_rev(out_k))};
            checks++;
            if (out_data !== exp) begin
                errors++;
                $display("FAIL R2 cube %0d word %0d actual %h expected %h",
                         out_cube, out_k, out_data, exp);
            end
            if (out_k == 0) fv[out_cube] = cyc;
            out_total++;
            out_k++;
            if (out_k == CUBE) begin
                out_k = 0;
                out_cube++;
            end
        end
    end

    task automatic send_cube(input int id, input int gap, input bit first);
        for (int pos = 0; pos < CUBE; pos++) begin
            int idles = 0;
            if (gap == 1 && pos % 4 == 0) idles = 1;
            if (gap == 2 && pos % 3 == 1) idles = 2;
            for (int g = 0; g < idles; g++) begin
                in_valid = 1'b0;
                in_first = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_first = first && (pos == 0);
            in_data  = {id[7:0], 8'(pos)};
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        exp_ids[n_sent] = id;
        lacc[n_sent] = cyc;
        n_sent++;
    endtask

    task automatic send_partial(input int id, input int len);
        for (int pos = 0; pos < len; pos++) begin
            in_valid = 1'b1;
            in_first = (pos == 0);
            in_data  = {id[7:0], 8'(pos)};
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    task automatic wait_total(input int n);
        while (out_total < n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        mon_en = 1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 after reset", int'(out_valid), 0);

        // table walk: R2, R4, R5 and boundary in_first (R6)
        for (int i = 0; i < NVEC; i++) begin
            send_cube(i + 1, GAP_TBL[i], FIRST_TBL[i] != 0);
        end
        wait_total(NVEC * CUBE);
        check(fv[0] == lacc[0] + 2, "R3 first cube latency", fv[0] - lacc[0], 2);
        check(fv[1] == fv[0] + CUBE, "R4 seamless cube 1", fv[1] - fv[0], CUBE);
        check(fv[2] == fv[1] + CUBE, "R4 seamless cube 2 with boundary in_first",
              fv[2] - fv[1], CUBE);
        check(fv[4] > fv[3], "R5 gapped cubes ordered", fv[4] - fv[3], 1);

        // idle: R7
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7 idle after drain", int'(out_valid), 0);
        end
        check(out_total == NVEC * CUBE, "R7 word count", out_total, NVEC * CUBE);

        // restarts: R6
        send_partial(50, 20);
        send_cube(51, 0, 1'b1);
        send_partial(52, CUBE - 1);
        send_cube(53, 0, 1'b1);
        wait_total((NVEC + 2) * CUBE);
        repeat (CUBE + 8) @(negedge clk);
        check(out_total == (NVEC + 2) * CUBE, "R6 partial cubes discarded",
              out_total, (NVEC + 2) * CUBE);
        check(fv[NVEC] == lacc[NVEC] + 2, "R3 latency after restart",
              fv[NVEC] - lacc[NVEC], 2);
        check(out_valid == 1'b0, "R7 idle at end", int'(out_valid), 0);
        finish_run();
    end
endmodule